// File: doc/BRIEF.md
# Iterative Carry-XOR Adder/Subtractor

This block adds or subtracts two signed two's-complement operands without a carry chain. It keeps two registers, a carry word and an exclusive-OR word. Each clock it rewrites the pair: the carry word becomes the bitwise AND of the two words moved up one bit, with a 0 entering at bit 0, and the exclusive-OR word becomes their bitwise XOR. The sum of the two words never changes modulo the register width. When the carry word is all zeros, the exclusive-OR word holds the answer.

Operands are `DW` bits wide and are sign-extended into registers of `DW+1` bits. That extra guard bit makes every sum or difference of two operands representable. For a subtraction the second operand is negated before it is loaded. When the positive operand has the larger magnitude, the carry would grow forever in unlimited width. In fixed width the carry bits drop off the top, so every operation ends within `DW+1` steps. The latency depends on the data, and most operand pairs finish in a few cycles.

Top module: `cxa_addsub`

## Requirements
- R1: After reset, `busy`, `done`, `sign`, `result` and `iters` are all 0.
- R2: With `sub`=0, `result` equals the sign-extended `opa` plus the sign-extended `opb`, as a `DW+1`-bit two's-complement value.
- R3: With `sub`=1, `result` equals the sign-extended `opa` minus the sign-extended `opb`, as a `DW+1`-bit two's-complement value. This includes `opb` at the most negative operand value.
- R4: `sign` equals bit `DW` (the top bit) of `result`. A 1 marks a negative result.
- R5: `iters` reports the number of carry/XOR rewrite steps taken before the carry word reached zero. When `opa` is 0, no step is taken, `iters` is 0, and `done` rises on the first clock edge after the accepted start.
- R6: Every operation ends with `iters` at most `DW+1`, including mixed-sign pairs whose positive magnitude is larger or equal. For example, 2 plus -2 takes `DW` steps and gives 0.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running operation completes with its own operands.
- R8: `done` is a one-cycle pulse that appears exactly `iters`+1 clock edges after the edge that accepted `start`. `result`, `sign` and `iters` then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| sub | input | 1 | 1 selects opa - opb, 0 selects opa + opb |
| opa | input | DW | First signed operand |
| opb | input | DW | Second signed operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW+1 | Signed sum or difference |
| sign | output | 1 | Sign of result |
| iters | output | $clog2(DW+2)+1 | Rewrite steps taken by the last operation |

## Verification
A corrupted carry or exclusive-OR bit breaks the invariant that the two words sum to the loaded total. The sum then shows up wrong on `result` at the next `done`. Because the carry may also clear early or late, the error can appear instead as a changed `iters` value or a shifted `done` cycle. A controller fault, such as a start taken while busy or a counter that is not cleared, shows on the very next completion as a wrong value or a wrong latency. Comparing the expected latency against the cycle count of every operation catches these faults within one operation.

// File: rtl/cxa_pkg.sv
package cxa_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cxa_state_e;
endpackage

// File: rtl/cxa_loader.sv
module cxa_loader #(
  parameter int DW = 8,
  localparam int RW = DW + 1
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          sub,
  output logic [RW-1:0] carry_init,
  output logic [RW-1:0] xor_init
);
  logic [RW-1:0] a_ext;
  logic [RW-1:0] b_ext;
  logic [RW-1:0] b_neg;

  always_comb begin
    a_ext = {opa[DW-1], opa};
    b_ext = {opb[DW-1], opb};
    // two's complement negation: invert, then add one
    b_neg = (~b_ext) + RW'(1);
    carry_init = a_ext;
    xor_init   = sub ? b_neg : b_ext;
  end
endmodule

// File: rtl/cxa_step.sv
module cxa_step #(
  parameter int RW = 9
) (
  input  logic [RW-1:0] carry_cur,
  input  logic [RW-1:0] xor_cur,
  output logic [RW-1:0] carry_nxt,
  output logic [RW-1:0] xor_nxt,
  output logic          carry_zero
);
  assign carry_nxt[0] = 1'b0;
  assign xor_nxt[0]   = carry_cur[0] ^ xor_cur[0];

  for (genvar i = 1; i < RW; i++) begin : g_bit
    assign carry_nxt[i] = carry_cur[i-1] & xor_cur[i-1];
    assign xor_nxt[i]   = carry_cur[i] ^ xor_cur[i];
  end

  assign carry_zero = (carry_cur == '0);
endmodule

// File: rtl/cxa_ctrl.sv
module cxa_ctrl #(
  parameter int RW = 9,
  localparam int CW = $clog2(RW + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          carry_zero,
  output logic          load,
  output logic          step,
  output logic          fin,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] iters
);
  import cxa_pkg::*;

  cxa_state_e state_q;

  always_comb begin
    load = (state_q == ST_IDLE) && start;
    fin  = (state_q == ST_RUN) && carry_zero;
    step = (state_q == ST_RUN) && !carry_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      iters   <= '0;
    end else begin
      done <= fin;
      if (load) begin
        state_q <= ST_RUN;
        iters   <= '0;
      end else if (fin) begin
        state_q <= ST_IDLE;
      end else if (step) begin
        iters <= iters + CW'(1);
      end
    end
  end

  assign busy = (state_q == ST_RUN);

  // R8: done lasts one cycle only
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: the step count never exceeds the register width
  a_r6_iter_bound: assert property (@(posedge clk) disable iff (rst)
    iters <= CW'(RW));

  // R8: the count is frozen while idle without a start
  a_r8_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(iters));
endmodule

// File: rtl/cxa_addsub.sv
module cxa_addsub #(
  parameter int DW = 8,
  localparam int RW = DW + 1,
  localparam int CW = $clog2(RW + 1) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sub,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] result,
  output logic          sign,
  output logic [CW-1:0] iters
);
  logic [RW-1:0] carry_q, xor_q;
  logic [RW-1:0] carry_init, xor_init;
  logic [RW-1:0] carry_nxt, xor_nxt;
  logic          carry_zero;
  logic          load, step, fin;

  cxa_loader #(.DW(DW)) u_loader (
    .opa        (opa),
    .opb        (opb),
    .sub        (sub),
    .carry_init (carry_init),
    .xor_init   (xor_init)
  );

  cxa_step #(.RW(RW)) u_step (
    .carry_cur  (carry_q),
    .xor_cur    (xor_q),
    .carry_nxt  (carry_nxt),
    .xor_nxt    (xor_nxt),
    .carry_zero (carry_zero)
  );

  cxa_ctrl #(.RW(RW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .carry_zero (carry_zero),
    .load       (load),
    .step       (step),
    .fin        (fin),
    .busy       (busy),
    .done       (done),
    .iters      (iters)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= '0;
      xor_q   <= '0;
      result  <= '0;
      sign    <= 1'b0;
    end else begin
      if (load) begin
        carry_q <= carry_init;
        xor_q   <= xor_init;
      end else if (step) begin
        carry_q <= carry_nxt;
        xor_q   <= xor_nxt;
      end
      if (fin) begin
        result <= xor_q;
        sign   <= xor_q[RW-1];
      end
    end
  end

  // checker state: the total captured at load time
  logic [RW-1:0] chk_total_q;
  always_ff @(posedge clk) begin
    if (rst)       chk_total_q <= '0;
    else if (load) chk_total_q <= RW'(carry_init + xor_init);
  end

  // R2 / R3: carry word plus XOR word keeps the loaded total
  a_r2_sum_invariant: assert property (@(posedge clk) disable iff (rst)
    busy |-> (RW'(carry_q + xor_q) == chk_total_q));

  // R6: after any step the carry LSB is zero
  a_r6_carry_lsb_clear: assert property (@(posedge clk) disable iff (rst)
    step |=> (carry_q[0] == 1'b0));

  // R7: a start while busy does not reload the registers
  a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !carry_zero) |=> (xor_q == $past(xor_nxt)));

  // R5: done means the carry word reached zero
  a_r5_done_carry_zero: assert property (@(posedge clk) disable iff (rst)
    done |-> (carry_q == '0));

  // R8: the result holds while idle without a start
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));
endmodule

// File: tb/test_cxa_addsub.sv
`timescale 1ns/1ps
module test_cxa_addsub;
  localparam int DW = 8;
  localparam int RW = DW + 1;
  localparam int CW = $clog2(RW + 1) + 1;
  localparam int NV = 14;

  localparam int VA  [NV] = '{5, -6, 14, -14, -1, -17, 127, -128, 10, 3, 0, -128, 2, -3};
  localparam int VB  [NV] = '{3, 12, -11, -14, -6, 11, 127, -128, 3, 10, -128, 127, -2, 2};
  localparam int VOP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0};
  localparam int VEXP[NV] = '{8, 6, 3, -28, -7, -6, 254, -256, 7, -7, 128, -255, 0, -1};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          sub = 1'b0;
  logic [DW-1:0] opa = '0;
  logic [DW-1:0] opb = '0;
  logic          busy, done, sign;
  logic [RW-1:0] result;
  logic [CW-1:0] iters;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cxa_addsub #(.DW(DW)) i_cxa_addsub (
    .clk(clk), .rst(rst), .start(start), .sub(sub), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result), .sign(sign), .iters(iters)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_steps(input logic [RW-1:0] c0, input logic [RW-1:0] x0);
    logic [RW-1:0] c = c0;
    logic [RW-1:0] x = x0;
    logic [RW-1:0] t;
    int n = 0;
    while (c != '0 && n < 64) begin
      t = c & x;
      x = x ^ c;
      c = {t[RW-2:0], 1'b0};
      n++;
    end
    return n;
  endfunction

  task automatic run_op(input int a, input int b, input bit s, output int lat);
    @(negedge clk);
    opa = DW'(a); opb = DW'(b); sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    int steps;
    logic [RW-1:0] bx;
    logic [RW-1:0] hold_r;
    logic [CW-1:0] hold_i;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && sign == 0, "R1 flags", int'({busy, done, sign}), 0);
    check(result == '0 && iters == '0, "R1 values", int'(result) + int'(iters), 0);
    rst = 1'b0;
    @(negedge clk);

    // table: R2 add, R3 subtract, R4 sign, R5 count, R6 bound, R8 latency
    for (int v = 0; v < NV; v++) begin
      run_op(VA[v], VB[v], VOP[v][0], lat);
      bx = {opb[DW-1], opb};
      if (VOP[v] != 0) bx = ~bx + RW'(1);
      steps = ref_steps({opa[DW-1], opa}, bx);
      check(result == RW'(VEXP[v]), (VOP[v] != 0) ? "R3 difference" : "R2 sum",
            int'(result), int'(RW'(VEXP[v])));
      check(sign == (VEXP[v] < 0), "R4 sign", int'(sign), int'(VEXP[v] < 0));
      check(int'(iters) == steps, "R5 iteration count", int'(iters), steps);
      check(int'(iters) <= RW, "R6 iteration bound", int'(iters), RW);
      check(lat == steps + 1, "R8 done latency", lat, steps + 1);
    end

    // R5: zero first operand, no steps, done one edge after accept
    run_op(0, 55, 1'b0, lat);
    check(iters == '0, "R5 zero steps", int'(iters), 0);
    check(lat == 1, "R5 immediate done", lat, 1);
    check(result == RW'(55), "R5 zero-step result", int'(result), 55);

    // R6: 2 + -2 needs DW steps and gives 0
    run_op(2, -2, 1'b0, lat);
    check(int'(iters) == DW, "R6 wrap terminates", int'(iters), DW);
    check(result == '0, "R6 wrap result", int'(result), 0);

    // R5: -3 + 2 finishes in a single step with -1
    run_op(-3, 2, 1'b0, lat);
    check(int'(iters) == 1, "R5 complementary pair", int'(iters), 1);
    check(result == '1, "R5 complementary result", int'(result), int'(RW'(-1)));

    // R8: done is a pulse and outputs hold
    hold_r = result; hold_i = iters;
    @(negedge clk);
    check(done == 0, "R8 done pulse", int'(done), 0);
    repeat (4) @(negedge clk);
    check(result == hold_r && iters == hold_i, "R8 hold", int'(result), int'(hold_r));

    // R7: start while busy is ignored
    @(negedge clk);
    opa = DW'(2); opb = DW'(-2); sub = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    opa = DW'(1); opb = DW'(1); sub = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check(result == '0, "R7 result unchanged", int'(result), 0);
    check(int'(iters) == DW, "R7 count unchanged", int'(iters), DW);
    @(negedge clk);
    check(busy == 0, "R7 no second run", int'(busy), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule